// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block overlays a small hardware cursor on a raster video stream. Software writes two 32x32 bit planes (a shape mask and a colour-select plane, one 32-bit word per cursor row) and a packed X/Y position through a 32-bit register bus. During scan-out the block receives every pixel's coordinate and its underlying colour. Inside the cursor square, a set mask bit replaces the pixel with one of two overlay colours, chosen by the colour-select bit. Everywhere else the pixel passes through unchanged.

The result is registered, so it appears one clock after the pixel enters. Drawing is clipped at the right edge of the visible width. The two overlay colours come from outside the block, because palette storage lives elsewhere. A general-purpose control word is also stored; it reads back with one status bit forced high. After reset the cursor sits far off screen, so it is invisible until software moves it.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the position is X=0xF000, Y=0xF000, both planes are zero, the control word is zero, and every pixel passes through unchanged.
- R2: A write to offset 0x8FC loads X from write data bits [31:16] and Y from bits [15:0].
- R3: A write to offset 0x900 + 4*r (r = 0..31) loads mask row r. A write to offset 0x980 + 4*r loads colour-select row r.
- R4: Scan rows Y through Y+31 are covered, and row (scan_y - Y) of each plane is used. The sum Y+32 does not wrap: with Y=0xFFF0, scan row 0x0005 is not covered.
- R5: Inside a row, pixel X+i uses bit (31 - i) of the row word, so the leftmost cursor pixel is bit 31.
- R6: Where the mask bit is 1, the output is ovl_color1 if the colour-select bit is 1 and ovl_color0 if it is 0. Where the mask bit is 0, pix_color passes through.
- R7: Pixels with pix_x >= disp_width are never altered. At most min(32, width - X) pixels of a row are affected, and nothing is drawn when X >= disp_width.
- R8: Reading offset 0x818 returns the stored control word with bit 25 forced to 1. Writes to 0x818 store all 32 bits. Reads at any other offset return zero, and writes to unmapped offsets change nothing.
- R9: out_valid and out_color reflect the pixel presented on the previous clock cycle. out_valid follows pix_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ctrl_word | output | 32 | Stored control word |
| disp_width | input | 16 | Visible display width in pixels |
| pix_valid | input | 1 | Pixel input valid |
| pix_x | input | 16 | Pixel column |
| pix_y | input | 16 | Pixel row |
| pix_color | input | 24 | Underlying pixel colour |
| ovl_color0 | input | 24 | Overlay colour where colour-select bit is 0 |
| ovl_color1 | input | 24 | Overlay colour where colour-select bit is 1 |
| out_valid | output | 1 | Output pixel valid |
| out_color | output | 24 | Output pixel colour |

## Verification
The bench uses the default parameters: a 32-pixel cursor square, 16-bit coordinates and 24-bit colours. The display widths are small, between 40 and 200 pixels, and the cursor positions lie close to the right edge. This makes clipping at the edge, and cursors that lie completely beyond it, frequent under random stimulus. Directed cases put Y at 0xFFF0 to exercise the non-wrapping row window. They also place single-bit planes to pin down the bit order inside a row.

// File: rtl/cursor_pkg.sv
`timescale 1ns/1ps
package cursor_pkg;
    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h818;
    localparam logic [BUS_AW-1:0] OFS_POS  = 12'h8FC;
    localparam logic [BUS_AW-1:0] OFS_MASK = 12'h900;
    localparam logic [BUS_AW-1:0] OFS_SEL  = 12'h980;

    localparam logic [BUS_DW-1:0] CTRL_FORCED = 32'h0200_0000;
    localparam logic [15:0]       HIDDEN_POS  = 16'hF000;

    typedef enum logic [1:0] {
        PICK_PASS = 2'd0,
        PICK_C0   = 2'd1,
        PICK_C1   = 2'd2
    } pick_e;
endpackage

// File: rtl/cursor_regs.sv
`timescale 1ns/1ps
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int CUR_DIM = 32,
    parameter int COORD_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [BUS_AW-1:0]               addr,
    input  logic [BUS_DW-1:0]               wdata,
    output logic [BUS_DW-1:0]               rdata,
    output logic [BUS_DW-1:0]               ctrl,
    output logic [COORD_W-1:0]              pos_x,
    output logic [COORD_W-1:0]              pos_y,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0] mask_rows,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0] sel_rows
);
    localparam int IDX_W = $clog2(CUR_DIM);
    localparam logic [BUS_AW-1:0] SPAN = BUS_AW'(4 * CUR_DIM);

    typedef struct packed {
        logic [BUS_DW-1:0]               ctrl;
        logic [COORD_W-1:0]              x;
        logic [COORD_W-1:0]              y;
        logic [CUR_DIM-1:0][CUR_DIM-1:0] mask;
        logic [CUR_DIM-1:0][CUR_DIM-1:0] sel;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_mask, hit_sel;
    logic [IDX_W-1:0] mask_idx, sel_idx;

    always_comb begin
        hit_mask = (addr >= OFS_MASK) && (addr < OFS_MASK + SPAN);
        hit_sel  = (addr >= OFS_SEL)  && (addr < OFS_SEL + SPAN);
        mask_idx = IDX_W'((addr - OFS_MASK) >> 2);
        sel_idx  = IDX_W'((addr - OFS_SEL) >> 2);
        r_d = r_q;
        if (wr_en) begin
            if (addr == OFS_CTRL) begin
                r_d.ctrl = wdata;
            end else if (addr == OFS_POS) begin
                r_d.x = COORD_W'(wdata[31:16]);
                r_d.y = COORD_W'(wdata[15:0]);
            end else if (hit_mask) begin
                r_d.mask[mask_idx] = wdata[BUS_DW-1 -: CUR_DIM];
            end else if (hit_sel) begin
                r_d.sel[sel_idx] = wdata[BUS_DW-1 -: CUR_DIM];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctrl <= '0;
            r_q.x    <= COORD_W'(HIDDEN_POS);
            r_q.y    <= COORD_W'(HIDDEN_POS);
            r_q.mask <= '0;
            r_q.sel  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata     = (addr == OFS_CTRL) ? (r_q.ctrl | CTRL_FORCED) : '0;
    assign ctrl      = r_q.ctrl;
    assign pos_x     = r_q.x;
    assign pos_y     = r_q.y;
    assign mask_rows = r_q.mask;
    assign sel_rows  = r_q.sel;

    // R2: a position write lands in the X/Y state on the next edge
    p_pos_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_POS) |=>
            (pos_x == COORD_W'($past(wdata[31:16])) &&
             pos_y == COORD_W'($past(wdata[15:0]))))
        else $error("p_pos_load_r2");

    // R8: the control word is untouched by writes elsewhere
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != OFS_CTRL) |=> $stable(ctrl))
        else $error("p_ctrl_hold_r8");
endmodule

// File: rtl/cursor_hit.sv
`timescale 1ns/1ps
module cursor_hit
    import cursor_pkg::*;
#(
    parameter int CUR_DIM = 32,
    parameter int COORD_W = 16
) (
    input  logic [COORD_W-1:0]              pix_x,
    input  logic [COORD_W-1:0]              pix_y,
    input  logic [COORD_W-1:0]              pos_x,
    input  logic [COORD_W-1:0]              pos_y,
    input  logic [COORD_W-1:0]              width,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0] mask_rows,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0] sel_rows,
    output pick_e                           pick
);
    localparam int IDX_W = $clog2(CUR_DIM);
    localparam logic [COORD_W:0]   SPAN  = (COORD_W+1)'(CUR_DIM);
    localparam logic [IDX_W-1:0]   LAST  = IDX_W'(CUR_DIM - 1);

    logic [COORD_W:0]  y_end, x_end;
    logic              in_rows, in_cols;
    logic [IDX_W-1:0]  row, col, bitpos;
    logic [CUR_DIM-1:0] mrow, srow;

    always_comb begin
        y_end   = {1'b0, pos_y} + SPAN;
        x_end   = {1'b0, pos_x} + SPAN;
        in_rows = (pix_y >= pos_y) && ({1'b0, pix_y} < y_end);
        in_cols = (pix_x >= pos_x) && ({1'b0, pix_x} < x_end) &&
                  (pix_x < width);
        row     = IDX_W'(pix_y - pos_y);
        col     = IDX_W'(pix_x - pos_x);
        bitpos  = LAST - col;
        mrow    = mask_rows[row];
        srow    = sel_rows[row];
        pick    = PICK_PASS;
        if (in_rows && in_cols && mrow[bitpos]) begin
            pick = srow[bitpos] ? PICK_C1 : PICK_C0;
        end
    end
endmodule

// File: rtl/cursor_mix.sv
`timescale 1ns/1ps
module cursor_mix
    import cursor_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  pick_e              pick,
    input  logic [COLOR_W-1:0] base_color,
    input  logic [COLOR_W-1:0] color0,
    input  logic [COLOR_W-1:0] color1,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color
);
    typedef struct packed {
        logic               vld;
        logic [COLOR_W-1:0] col;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d.vld = in_valid;
        unique case (pick)
            PICK_C0: s_d.col = color0;
            PICK_C1: s_d.col = color1;
            default: s_d.col = base_color;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.vld;
    assign out_color = s_q.col;

    // R9: valid emerges exactly one cycle after it enters
    p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)))
        else $error("p_valid_latency_r9");

    // R6: a pass-through decision forwards the underlying colour
    p_pass_color_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_PASS) |=> (out_color == $past(base_color)))
        else $error("p_pass_color_r6");
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int CUR_DIM = 32,
    parameter int COORD_W = 16,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_en,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    output logic [BUS_DW-1:0]  ctrl_word,
    input  logic [COORD_W-1:0] disp_width,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COLOR_W-1:0] pix_color,
    input  logic [COLOR_W-1:0] ovl_color0,
    input  logic [COLOR_W-1:0] ovl_color1,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color
);
    logic [COORD_W-1:0]              pos_x, pos_y;
    logic [CUR_DIM-1:0][CUR_DIM-1:0] mask_rows, sel_rows;
    pick_e                           pick;

    cursor_regs #(.CUR_DIM(CUR_DIM), .COORD_W(COORD_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .ctrl      (ctrl_word),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .mask_rows (mask_rows),
        .sel_rows  (sel_rows)
    );

    cursor_hit #(.CUR_DIM(CUR_DIM), .COORD_W(COORD_W)) i_hit (
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .width     (disp_width),
        .mask_rows (mask_rows),
        .sel_rows  (sel_rows),
        .pick      (pick)
    );

    cursor_mix #(.COLOR_W(COLOR_W)) i_mix (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (pix_valid),
        .pick       (pick),
        .base_color (pix_color),
        .color0     (ovl_color0),
        .color1     (ovl_color1),
        .out_valid  (out_valid),
        .out_color  (out_color)
    );

    // R7: pixels at or beyond the visible width are never altered
    p_clip_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x >= disp_width) |=> (out_color == $past(pix_color)))
        else $error("p_clip_pass_r7");

    // R8: only the control offset returns data, with bit 25 high
    p_read_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) ? (bus_rdata[25] && bus_rdata[24:0] == ctrl_word[24:0])
                               : (bus_rdata == '0))
        else $error("p_read_map_r8");
endmodule

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, ctrl_word;
    logic [15:0] disp_width = 16'd100;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [23:0] pix_color = '0;
    logic [23:0] ovl_color0 = 24'h00A0B0;
    logic [23:0] ovl_color1 = 24'hC0D0E0;
    logic        out_valid;
    logic [23:0] out_color;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_mask [32];
    logic [31:0] m_sel  [32];
    int          m_x, m_y;

    always #2.5 clk = ~clk;

    cursor_overlay i_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_word(ctrl_word),
        .disp_width(disp_width), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .pix_color(pix_color), .ovl_color0(ovl_color0),
        .ovl_color1(ovl_color1), .out_valid(out_valid), .out_color(out_color)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_pix(int x, int y, int w, logic [23:0] c);
        int r, i;
        if (y >= m_y && y < m_y + 32 && x >= m_x && x < m_x + 32 && x < w) begin
            r = y - m_y;
            i = x - m_x;
            if (m_mask[r][31-i]) return m_sel[r][31-i] ? ovl_color1 : ovl_color0;
        end
        return c;
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = 12'h000;
        if (a == 12'h8FC) begin m_x = int'(d[31:16]); m_y = int'(d[15:0]); end
        else if (a >= 12'h900 && a < 12'h980) m_mask[(a - 12'h900) >> 2] = d;
        else if (a >= 12'h980 && a < 12'hA00) m_sel[(a - 12'h980) >> 2] = d;
    endtask

    task automatic pix(string req, int x, int y, logic [23:0] c);
        logic [23:0] exp;
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_color = c;
        exp = ref_pix(x, y, int'(disp_width), c);
        @(posedge clk);
        #1;
        chk(req, {31'd0, out_valid}, 32'd1);
        chk(req, {8'd0, out_color}, {8'd0, exp});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_2468));
        for (int r = 0; r < 32; r++) begin m_mask[r] = '0; m_sel[r] = '0; end
        m_x = 16'hF000; m_y = 16'hF000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        bus_addr = 12'h818; #1;
        chk("R1 ctrl after reset", bus_rdata, 32'h0200_0000);
        chk("R1 valid idle", {31'd0, out_valid}, 32'd0);
        disp_width = 16'hFFFF;
        pix("R1 hidden cursor", 16'hF000, 16'hF000, 24'h123456);
        pix("R1 origin pass", 0, 0, 24'h654321);

        // R8: control word and read map
        wr(12'h818, 32'h0000_00A5);
        @(negedge clk); bus_addr = 12'h818; #1;
        chk("R8 ctrl readback", bus_rdata, 32'h0200_00A5);
        chk("R8 ctrl output", ctrl_word, 32'h0000_00A5);
        bus_addr = 12'h8FC; #1;
        chk("R8 pos reads zero", bus_rdata, 32'd0);
        bus_addr = 12'h900; #1;
        chk("R8 mask reads zero", bus_rdata, 32'd0);
        wr(12'h800, 32'hFFFF_FFFF);
        @(negedge clk); bus_addr = 12'h818; #1;
        chk("R8 unmapped write ignored", bus_rdata, 32'h0200_00A5);

        // R2 R3 R5 R6: bit order and colour choice
        disp_width = 16'd100;
        wr(12'h900, 32'hC000_0001);
        wr(12'h980, 32'h8000_0001);
        wr(12'h8FC, {16'd10, 16'd20});
        pix("R5 bit31 leftmost c1", 10, 20, 24'h111111);
        pix("R6 mask set sel0", 11, 20, 24'h222222);
        pix("R6 mask clear pass", 12, 20, 24'h333333);
        pix("R5 bit0 rightmost", 41, 20, 24'h444444);
        pix("R2 right of cursor", 42, 20, 24'h555555);
        pix("R2 row above", 10, 19, 24'h666666);
        wr(12'h97C, 32'h0000_0001);
        wr(12'h9FC, 32'h0000_0000);
        pix("R3 last row", 41, 51, 24'h777777);
        pix("R4 below window", 41, 52, 24'h888888);

        // R7: clipping at the right edge
        disp_width = 16'd12;
        pix("R7 last visible", 10, 20, 24'h999999);
        wr(12'h900, 32'hFFFF_FFFF);
        pix("R7 edge pixel", 11, 20, 24'hAAAAAA);
        pix("R7 clipped", 12, 20, 24'hBBBBBB);
        wr(12'h8FC, {16'd12, 16'd20});
        pix("R7 x at width", 12, 20, 24'hCCCCCC);

        // R4: no wrap of the row window
        disp_width = 16'd100;
        wr(12'h8FC, {16'd0, 16'hFFF0});
        wr(12'h900 + 12'd60, 32'hFFFF_FFFF);
        pix("R4 no wrap", 0, 5, 24'hDDDDDD);
        pix("R4 bottom row 0xFFFF", 0, 16'hFFFF, 24'hEEEEEE);

        // R9: valid drops one cycle after input drops
        @(negedge clk); pix_valid = 1'b0;
        @(posedge clk); #1;
        chk("R9 valid low", {31'd0, out_valid}, 32'd0);

        // Random mix: R3 R5 R6 R7
        for (int n = 0; n < 40; n++) begin
            disp_width = 16'(40 + $urandom_range(0, 160));
            for (int r = 0; r < 4; r++) begin
                int row = $urandom_range(0, 31);
                wr(12'h900 + 12'(4 * row), $urandom);
                wr(12'h980 + 12'(4 * row), $urandom);
            end
            if ($urandom_range(0, 9) == 0)
                wr(12'h8FC, {16'hF000, 16'hF000});
            else
                wr(12'h8FC, {16'(int'(disp_width) - 40 + $urandom_range(0, 50)),
                             16'($urandom_range(0, 60))});
            for (int k = 0; k < 40; k++) begin
                int x = m_x - 4 + $urandom_range(0, 44);
                int y = m_y - 4 + $urandom_range(0, 44);
                pix("R6 random", x & 16'hFFFF, y & 16'hFFFF, 24'($urandom));
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule